// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Register File

This block holds the digital side of a four-channel digital-to-analog converter. A 16-bit register bus writes staging (shadow) registers: one mode word, one per-channel range word and four 12-bit code words. Nothing written to a staging register reaches the converter pins until a bus read of a specific offset copies it into the active stage. Reads therefore act as update strobes. One strobe offset moves all four codes at once. A second strobe offset moves the range word.

The mode word carries a converter enable and a buffered-mode select. With buffered mode off, a code write goes through to its active register on the same clock edge as the shadow. With the enable clear, every channel presents the mid-scale code and the stored values stay untouched. The range word packs a polarity bit and a gain bit for each channel in descending channel order. A bus interface writes the registers and issues the strobes. The active outputs drive the converters directly.

Top module: `dac_dbuf_regs`

## Requirements
- R1: After reset, every code output reads 0x800, every polarity and gain output reads 0, and the enable and buffered-mode bits are both 0.
- R2: A write to offset 0x02 sets the enable from data bit 1 and buffered mode from data bit 0. The new mode governs accesses from the following cycle onward.
- R3: While the enable is 0, all four code outputs read 0x800. Setting the enable again shows the active codes held before, unchanged.
- R4: Writes to offsets 0x14, 0x16, 0x18 and 0x1A load the code shadows of channels 0, 1, 2 and 3. Only data bits 11:0 are kept, and bits 15:12 are dropped.
- R5: In buffered mode, a code write leaves every code output unchanged until a read of offset 0x02. That read loads all four active codes from their shadows on the same clock edge.
- R6: With buffered mode off, a code write appears on that channel's code output at the clock edge that captures the write.
- R7: A write to offset 0x12 loads the range shadow, and its bits do not reach the outputs until a read of offset 0x12. After that read, channel n's polarity output equals bit 7-n of the range word (1 = bipolar) and its gain output equals bit 11-n.
- R8: When a write and the matching update read occur in the same cycle, the newly written value is transferred. This applies to a code write with a 0x02 read and to a range write with a 0x12 read.
- R9: Writes to any offset other than 0x02, 0x12 and 0x14 to 0x1A leave the outputs unchanged. Reads of any offset other than 0x02 and 0x12 also leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write valid |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Bus read valid (acts as an update strobe) |
| rd_addr | input | 8 | Byte offset of the read |
| dac_code | output | 48 | Active codes, channel n at bits 12n+11:12n |
| dac_bipolar | output | 4 | Active polarity per channel, 1 = bipolar |
| dac_gain | output | 4 | Active gain select per channel |

## Verification
The hardest situation to reach is a write colliding with its own update strobe. On a bus with one master this never happens naturally. The bench has independent write and read channels and drives a code write together with a 0x02 read in one cycle, and a range write together with a 0x12 read. It also sends a long random burst in which mode changes, collisions and stray offsets overlap. A behavioural model checks every cycle of that burst.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
   // Byte offsets decoded by the block
   localparam logic [7:0] OFS_MODE     = 8'h02;   // write: mode word, read: code update strobe
   localparam logic [7:0] OFS_RANGE    = 8'h12;   // write: range shadow, read: range update strobe
   localparam logic [7:0] OFS_CODE0    = 8'h14;   // first code shadow, channels spaced by 2
   localparam int         CODE_STRIDE  = 2;

   // Mode word bit positions
   localparam int MODE_EN_BIT  = 1;
   localparam int MODE_BUF_BIT = 0;

   // Range word: channel n polarity at POL_TOP-n, gain at GAIN_TOP-n
   localparam int POL_TOP  = 7;
   localparam int GAIN_TOP = 11;

   typedef struct packed {
      logic en;
      logic buffered;
   } dac_mode_t;
endpackage

// File: rtl/dac_dbuf_decode.sv
module dac_dbuf_decode
   import dac_dbuf_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 8
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              hit_mode,
   output logic              hit_range,
   output logic [NUM_CH-1:0] hit_code,
   output logic              strobe_codes,
   output logic              strobe_range
);
   assign hit_mode     = wr_en && (wr_addr == ADDR_W'(OFS_MODE));
   assign hit_range    = wr_en && (wr_addr == ADDR_W'(OFS_RANGE));
   assign strobe_codes = rd_en && (rd_addr == ADDR_W'(OFS_MODE));
   assign strobe_range = rd_en && (rd_addr == ADDR_W'(OFS_RANGE));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_code_hit
      localparam int LANE_OFS = int'(OFS_CODE0) + CODE_STRIDE * n;
      assign hit_code[n] = wr_en && (wr_addr == ADDR_W'(LANE_OFS));
   end
endmodule

// File: rtl/dac_dbuf_ctl.sv
module dac_dbuf_ctl
   import dac_dbuf_pkg::*;
#(
   parameter int RNG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit_mode,
   input  logic             hit_range,
   input  logic             strobe_range,
   input  logic [1:0]       mode_bits,
   input  logic [RNG_W-1:0] range_bits,
   output dac_mode_t        mode,
   output logic [RNG_W-1:0] range_act
);
   logic [RNG_W-1:0] range_shd;
   logic [RNG_W-1:0] range_nxt;

   // write-first: a same-cycle write is what the strobe transfers
   assign range_nxt = hit_range ? range_bits : range_shd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= '0;
         range_shd <= '0;
         range_act <= '0;
      end else begin
         if (hit_mode) begin
            mode.en       <= mode_bits[MODE_EN_BIT];
            mode.buffered <= mode_bits[MODE_BUF_BIT];
         end
         range_shd <= range_nxt;
         if (strobe_range) range_act <= range_nxt;
      end
   end
endmodule

// File: rtl/dac_dbuf_lane.sv
module dac_dbuf_lane #(
   parameter int CODE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic              strobe,
   input  logic              pass_through,
   input  logic [CODE_W-1:0] code_in,
   output logic [CODE_W-1:0] code_act
);
   logic [CODE_W-1:0] shd;
   logic [CODE_W-1:0] shd_nxt;
   logic              load_act;

   assign shd_nxt  = hit ? code_in : shd;
   assign load_act = strobe || (hit && pass_through);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd      <= '0;
         code_act <= '0;
      end else begin
         shd <= shd_nxt;
         if (load_act) code_act <= shd_nxt;
      end
   end
endmodule

// File: rtl/dac_dbuf_regs.sv
module dac_dbuf_regs
   import dac_dbuf_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int CODE_W   = 12,
   parameter int BUS_W    = 16,
   parameter int ADDR_W   = 8,
   parameter bit HOLD_MID = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        wr_addr,
   input  logic [BUS_W-1:0]         wr_data,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_bipolar,
   output logic [NUM_CH-1:0]        dac_gain
);
   localparam int RNG_LO = POL_TOP - 3;
   localparam int RNG_W  = GAIN_TOP - RNG_LO + 1;
   localparam logic [CODE_W-1:0] OFF_CODE = HOLD_MID ? CODE_W'(1) << (CODE_W - 1) : '0;

   // elaboration-time parameter checks
   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("dac_dbuf_regs: NUM_CH must be 1..4");
   end
   if (CODE_W > BUS_W || GAIN_TOP >= BUS_W || CODE_W < 2) begin : g_bad_w
      $error("dac_dbuf_regs: code and range fields must fit the bus");
   end
   if (ADDR_W < 5) begin : g_bad_a
      $error("dac_dbuf_regs: ADDR_W too small for the register offsets");
   end

   logic              hit_mode, hit_range, strobe_codes, strobe_range;
   logic [NUM_CH-1:0] hit_code;
   dac_mode_t         mode;
   logic              mode_en, mode_buf;
   logic [RNG_W-1:0]  range_act;

   assign mode_en  = mode.en;
   assign mode_buf = mode.buffered;

   if (BUS_W > CODE_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wr_data[BUS_W-1:CODE_W];
   end

   dac_dbuf_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .rd_en       (rd_en),
      .rd_addr     (rd_addr),
      .hit_mode    (hit_mode),
      .hit_range   (hit_range),
      .hit_code    (hit_code),
      .strobe_codes(strobe_codes),
      .strobe_range(strobe_range)
   );

   dac_dbuf_ctl #(.RNG_W(RNG_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_mode    (hit_mode),
      .hit_range   (hit_range),
      .strobe_range(strobe_range),
      .mode_bits   (wr_data[1:0]),
      .range_bits  (wr_data[GAIN_TOP:RNG_LO]),
      .mode        (mode),
      .range_act   (range_act)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic [CODE_W-1:0] act;

      dac_dbuf_lane #(.CODE_W(CODE_W)) u_lane (
         .clk         (clk),
         .rst_n       (rst_n),
         .hit         (hit_code[n]),
         .strobe      (strobe_codes),
         .pass_through(!mode_buf),
         .code_in     (wr_data[CODE_W-1:0]),
         .code_act    (act)
      );

      assign dac_code[n*CODE_W +: CODE_W] = mode_en ? act : OFF_CODE;
      // range word is laid out in descending channel order
      assign dac_bipolar[n] = range_act[POL_TOP - n - RNG_LO];
      assign dac_gain[n]    = range_act[GAIN_TOP - n - RNG_LO];
   end

   if (NUM_CH < 4) begin : g_spare_rng
      logic unused_rng;
      assign unused_rng = ^range_act;
   end
endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk
   import dac_dbuf_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int CODE_W   = 12,
   parameter int BUS_W    = 16,
   parameter int ADDR_W   = 8,
   parameter bit HOLD_MID = 1'b1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        wr_addr,
   input logic [BUS_W-1:0]         wr_data,
   input logic                     rd_en,
   input logic [ADDR_W-1:0]        rd_addr,
   input logic [NUM_CH*CODE_W-1:0] dac_code,
   input logic [NUM_CH-1:0]        dac_bipolar,
   input logic [NUM_CH-1:0]        dac_gain,
   input logic                     mode_en,
   input logic                     mode_buf
);
   localparam logic [CODE_W-1:0] OFF_CODE = HOLD_MID ? CODE_W'(1) << (CODE_W - 1) : '0;

   logic wr_mode_c, wr_rng_c, rd_codes_c, rd_rng_c;
   assign wr_mode_c  = wr_en && (wr_addr == ADDR_W'(OFS_MODE));
   assign wr_rng_c   = wr_en && (wr_addr == ADDR_W'(OFS_RANGE));
   assign rd_codes_c = rd_en && (rd_addr == ADDR_W'(OFS_MODE));
   assign rd_rng_c   = rd_en && (rd_addr == ADDR_W'(OFS_RANGE));

   logic unused_chk;
   assign unused_chk = ^wr_data[BUS_W-1:CODE_W];

   // R5: buffered and enabled, no code strobe and no mode change keep codes frozen
   assert_buf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_en && mode_buf && !rd_codes_c && !wr_mode_c) |=> $stable(dac_code));

   // R7: range outputs move only on the range strobe
   assert_rng_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_rng_c |=> ($stable(dac_bipolar) && $stable(dac_gain)));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      localparam int LANE_OFS = int'(OFS_CODE0) + CODE_STRIDE * n;

      // R3: disabling the converters shows the off code on every channel
      assert_off_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_mode_c && !wr_data[MODE_EN_BIT]) |=> (dac_code[n*CODE_W +: CODE_W] == OFF_CODE));

      // R6: unbuffered write reaches the output at the capturing edge
      assert_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_en && !mode_buf && !wr_mode_c && wr_en && wr_addr == ADDR_W'(LANE_OFS))
         |=> (dac_code[n*CODE_W +: CODE_W] == $past(wr_data[CODE_W-1:0])));

      // R8: range write colliding with its strobe transfers the new word
      assert_rng_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_rng_c && rd_rng_c) |=>
         (dac_bipolar[n] == $past(wr_data[POL_TOP - n]) && dac_gain[n] == $past(wr_data[GAIN_TOP - n])));
   end
endmodule

bind dac_dbuf_regs dac_dbuf_chk #(
   .NUM_CH(NUM_CH), .CODE_W(CODE_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .HOLD_MID(HOLD_MID)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .rd_en(rd_en), .rd_addr(rd_addr), .dac_code(dac_code), .dac_bipolar(dac_bipolar),
   .dac_gain(dac_gain), .mode_en(mode_en), .mode_buf(mode_buf)
);

// File: tb/dac_dbuf_regs_test.sv
`timescale 1ns/1ps
module dac_dbuf_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [7:0]  rd_addr = '0;
   logic [47:0] dac_code;
   logic [3:0]  dac_bipolar;
   logic [3:0]  dac_gain;

   always #2.5 clk = ~clk;

   dac_dbuf_regs uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .dac_code(dac_code),
      .dac_bipolar(dac_bipolar), .dac_gain(dac_gain)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string cur_req = "R1";
   bit    done = 0;

   // behavioural reference state
   int m_shd[4];
   int m_act[4];
   int m_en, m_buf, m_rshd, m_ract;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_shd[i] = 0; m_act[i] = 0; end
         m_en = 0; m_buf = 0; m_rshd = 0; m_ract = 0;
      end else begin
         int was_buf;
         was_buf = m_buf;
         if (wr_en) begin
            for (int i = 0; i < 4; i++)
               if (wr_addr == 8'h14 + 2*i) begin
                  m_shd[i] = wr_data & 'hFFF;
                  if (!was_buf) m_act[i] = m_shd[i];
               end
            if (wr_addr == 8'h12) m_rshd = wr_data;
         end
         if (rd_en && rd_addr == 8'h02)
            for (int i = 0; i < 4; i++) m_act[i] = m_shd[i];
         if (rd_en && rd_addr == 8'h12) m_ract = m_rshd;
         if (wr_en && wr_addr == 8'h02) begin
            m_en  = (wr_data >> 1) & 1;
            m_buf = wr_data & 1;
         end
      end
   end

   task automatic note_fail(string req, string what, int act, int exp);
      n_bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
   endtask

   // full comparison against the model every cycle
   always @(negedge clk) begin
      if (!done) begin
         for (int i = 0; i < 4; i++) begin
            int exp_c;
            exp_c = m_en ? m_act[i] : 'h800;
            n_vec++;
            if (int'(dac_code[12*i +: 12]) != exp_c) note_fail(cur_req, $sformatf("code ch%0d", i), int'(dac_code[12*i +: 12]), exp_c);
            n_vec++;
            if (int'(dac_bipolar[i]) != ((m_ract >> (7-i)) & 1)) note_fail(cur_req, $sformatf("bipolar ch%0d", i), int'(dac_bipolar[i]), (m_ract >> (7-i)) & 1);
            n_vec++;
            if (int'(dac_gain[i]) != ((m_ract >> (11-i)) & 1)) note_fail(cur_req, $sformatf("gain ch%0d", i), int'(dac_gain[i]), (m_ract >> (11-i)) & 1);
         end
      end
   end

   task automatic expect_v(string req, string what, int act, int exp);
      n_vec++;
      if (act != exp) note_fail(req, what, act, exp);
   endtask

   task automatic drive(bit we, int wa, int wd, bit re, int ra);
      @(negedge clk);
      wr_en = we; wr_addr = 8'(wa); wr_data = 16'(wd);
      rd_en = re; rd_addr = 8'(ra);
   endtask

   task automatic bus_wr(int a, int d); drive(1, a, d, 0, 0); endtask
   task automatic bus_rd(int a);        drive(0, 0, 0, 1, a); endtask
   task automatic idle(int k);
      for (int i = 0; i < k; i++) drive(0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      expect_v("R1", "code ch0 in reset", int'(dac_code[11:0]), 'h800);
      @(negedge clk); rst_n = 1'b1;
      idle(1);
      expect_v("R1", "code ch3 after reset", int'(dac_code[47:36]), 'h800);
      expect_v("R1", "range after reset", int'({dac_gain, dac_bipolar}), 0);

      cur_req = "R2";
      bus_wr('h02, 'h0002);           // enable, unbuffered
      idle(1);
      expect_v("R2", "enabled codes", int'(dac_code[11:0]), 0);

      cur_req = "R6";
      bus_wr('h14, 'hF123);
      idle(1);
      expect_v("R4", "upper bits dropped ch0", int'(dac_code[11:0]), 'h123);
      expect_v("R6", "pass-through ch0", int'(dac_code[11:0]), 'h123);
      bus_wr('h16, 'h0456); bus_wr('h18, 'h0789); bus_wr('h1A, 'h0FFF);
      idle(1);
      expect_v("R4", "ch3 offset 0x1A", int'(dac_code[47:36]), 'hFFF);

      cur_req = "R3";
      bus_wr('h02, 'h0000);
      idle(1);
      expect_v("R3", "disabled ch1", int'(dac_code[23:12]), 'h800);
      bus_wr('h16, 'h0111);           // unbuffered write while disabled
      bus_wr('h02, 'h0002);
      idle(1);
      expect_v("R3", "re-enabled ch1", int'(dac_code[23:12]), 'h111);

      cur_req = "R5";
      bus_wr('h02, 'h0003);           // buffered
      bus_wr('h18, 'h0ABC);
      bus_wr('h14, 'h0001);
      idle(3);
      expect_v("R5", "held ch2", int'(dac_code[35:24]), 'h789);
      bus_rd('h02);
      idle(1);
      expect_v("R5", "updated ch2", int'(dac_code[35:24]), 'hABC);
      expect_v("R5", "updated ch0", int'(dac_code[11:0]), 'h001);

      cur_req = "R7";
      bus_wr('h12, 'h0880);
      idle(2);
      expect_v("R7", "range not yet moved", int'({dac_gain, dac_bipolar}), 0);
      bus_rd('h12);
      idle(1);
      expect_v("R7", "ch0 bipolar+gain", int'({dac_gain, dac_bipolar}), 'h11);
      bus_wr('h12, 'h0F00); bus_rd('h12); bus_wr('h12, 'h00F0); bus_rd('h12);
      idle(1);
      expect_v("R7", "all bipolar", int'(dac_bipolar), 'hF);

      cur_req = "R8";
      drive(1, 'h1A, 'h0777, 1, 'h02);
      idle(1);
      expect_v("R8", "code write-first ch3", int'(dac_code[47:36]), 'h777);
      drive(1, 'h12, 'h0410, 1, 'h12);
      idle(1);
      expect_v("R8", "range write-first gain", int'(dac_gain), 'h2);
      expect_v("R8", "range write-first pol", int'(dac_bipolar), 'h8);

      cur_req = "R9";
      bus_wr('h04, 'hFFFF); bus_wr('h13, 'hFFFF); bus_wr('h1C, 'hFFFF); bus_wr('h00, 'hFFFF);
      bus_rd('h04); bus_rd('h14); bus_rd('h1A);
      idle(1);
      expect_v("R9", "stray access ch3", int'(dac_code[47:36]), 'h777);
      expect_v("R9", "stray access range", int'(dac_gain), 'h2);

      cur_req = "R8";                  // random mix incl. collisions and mode flips
      for (int k = 0; k < 400; k++) begin
         int sel_w, sel_r, wa, ra;
         sel_w = $urandom_range(0, 7);
         sel_r = $urandom_range(0, 5);
         wa = (sel_w < 4) ? 'h14 + 2*sel_w : (sel_w == 4) ? 'h02 : (sel_w == 5) ? 'h12 : 'h06;
         ra = (sel_r == 0) ? 'h02 : (sel_r == 1) ? 'h12 : 'h10;
         drive($urandom_range(0, 3) != 0, wa, $urandom_range(0, 'hFFFF),
               $urandom_range(0, 2) == 0, ra);
      end
      idle(2);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule